// File: doc/BRIEF.md
# Serial EEPROM Word-Erase Controller

This block is the host side of a three-wire serial EEPROM link: chip select, serial clock and a data-in line toward the memory, plus the memory's data-out line sampled back. A one-cycle `start_i` pulse with an address launches a single-word erase.

The controller clocks out the erase frame, then takes chip select low so the memory starts its self-timed erase. It keeps chip select low for a minimum gap, then raises it again and watches the data-out line for the ready/busy level. When the memory reports ready, the controller sends one start bit and drops chip select, which clears the ready/busy level from the line. It then pulses `done_o`. If ready never appears within a bounded number of samples, it pulses `timeout_o` instead.

The serial clock comes from a divider: each half period lasts `DIV_HALF` system cycles. The minimum chip-select gap is given in nanoseconds and converted to cycles from the system clock period. A mode input chosen per erase selects the variant in which the memory has already begun erasing before the last address bit.

Top module: `sep_erase_ctrl`

## Requirements
- R1: The frame on `di_o` is 1, 1, 1 and then the `ADDR_W` address bits, most significant first. Each bit is taken on a rising edge of `sck_o`, and `di_o` changes only while `sck_o` is low.
- R2: `sck_o` stays low and high for `DIV_HALF` cycles each. Its first rise comes `DIV_HALF` cycles after the edge that accepts the start, so rises are `2*DIV_HALF` cycles apart.
- R3: In normal mode (`early_mode_i`=0 at start), `cs_o` falls `2*DIV_HALF` cycles after the last address rise. In early mode (`early_mode_i`=1), it falls `DIV_HALF` cycles after that rise, on the same edge on which `sck_o` falls. `sck_o` is low whenever `cs_o` is low.
- R4: After the frame, `cs_o` stays low for exactly `CS_LOW_CYC` = ceil(`CS_LOW_NS`/`CLK_NS`) cycles and then rises.
- R5: With `cs_o` high after the gap, `do_i` is sampled every `2*DIV_HALF` cycles, the first time `2*DIV_HALF` cycles after `cs_o` rises. A sample of 1 means ready and 0 means busy. The first ready sample starts the clear step, whose `sck_o` rise comes `DIV_HALF` cycles later.
- R6: `do_i` has no effect while the frame is shifted or while `cs_o` is low.
- R7: The clear step drives `di_o`=1 for one `sck_o` pulse with `cs_o` still high. `cs_o` then falls on the same edge as that pulse's falling clock edge, and `done_o` is high for that one cycle.
- R8: If `MAX_POLLS` samples in a row read busy, `cs_o` falls and `timeout_o` pulses on the edge of the last sample, `2*DIV_HALF*MAX_POLLS` cycles after `cs_o` rose, with no clear pulse. `done_o` and `timeout_o` are never high together.
- R9: `busy_o` is high from the cycle after an accepted start until the result pulse, and is low in the cycle where `done_o` or `timeout_o` is high. `start_i` is ignored while `busy_o` is high, and `cs_o` is low whenever `busy_o` is low.
- R10: During reset, `cs_o`, `sck_o`, `di_o`, `busy_o`, `done_o` and `timeout_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle erase request |
| addr_i | input | ADDR_W | Word address to erase |
| early_mode_i | input | 1 | Selects the early-start variant for this erase |
| busy_o | output | 1 | Erase sequence in progress |
| done_o | output | 1 | One-cycle pulse: erase finished, status cleared |
| timeout_o | output | 1 | One-cycle pulse: ready not seen in time |
| cs_o | output | 1 | Chip select to the memory |
| sck_o | output | 1 | Serial clock to the memory |
| di_o | output | 1 | Serial data toward the memory |
| do_i | input | 1 | Serial data / ready-busy level from the memory |

## Verification
The bench builds the block with `ADDR_W`=7, `DIV_HALF`=3, `CLK_NS`=5, `CS_LOW_NS`=250 and `MAX_POLLS`=8. This gives a 50-cycle chip-select gap and a 48-cycle poll window. With these values, a run that is ready at the first sample, a run that is ready after several busy samples, and a run that exhausts the poll budget each finish in a few hundred cycles. A divider of 3 makes the one-half-period and two-half-period tails of the two modes differ by a clearly measurable amount. The bench memory model drives `do_i` high during the frame and the gap, so any sampling outside the poll phase would change the outcome.

// File: rtl/sep_pkg.sv
package sep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP,
    ST_POLL,
    ST_CLEAR
  } sep_state_e;
endpackage

// File: rtl/sep_tick_gen.sv
module sep_tick_gen #(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sep_span_cnt.sv
module sep_span_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = inc_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || hit_o) cnt_q <= '0;
    else if (inc_i)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sep_frame_shifter.sv
module sep_frame_shifter #(
  parameter int unsigned FRAME_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               bit_o,
  output logic               last_o
);
  localparam int unsigned IW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [IW-1:0]      idx_q;

  assign bit_o  = sr_q[FRAME_W-1];
  assign last_o = (idx_q == IW'(FRAME_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= frame_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sep_erase_ctrl.sv
module sep_erase_ctrl
  import sep_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DIV_HALF  = 4,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned CS_LOW_NS = 250,
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              early_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              cs_o,
  output logic              sck_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int unsigned FRAME_W    = ADDR_W + 3;
  localparam int unsigned CS_LOW_RAW = (CS_LOW_NS + CLK_NS - 1) / CLK_NS;
  localparam int unsigned CS_LOW_CYC = (CS_LOW_RAW == 0) ? 1 : CS_LOW_RAW;

  sep_state_e state_q;
  logic cs_q, sck_q, early_q, ph_q, done_q, tmo_q;
  logic tick, tick_en, load, shift, sr_bit, sr_last;
  logic gap_hit, poll_sample, poll_hit;

  assign tick_en     = state_q inside {ST_SHIFT, ST_TAIL, ST_POLL, ST_CLEAR};
  assign load        = (state_q == ST_IDLE) && start_i;
  // falling serial edge advances the frame; the final bit is held through the tail
  assign shift       = (state_q == ST_SHIFT) && tick && sck_q && !sr_last;
  assign poll_sample = (state_q == ST_POLL) && tick && ph_q;

  sep_tick_gen #(.DIV_HALF(DIV_HALF)) i_tick (
    .clk_i, .rst_ni, .en_i(tick_en), .tick_o(tick)
  );

  sep_frame_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i, .rst_ni, .load_i(load), .frame_i({3'b111, addr_i}),
    .shift_i(shift), .bit_o(sr_bit), .last_o(sr_last)
  );

  sep_span_cnt #(.LIMIT(CS_LOW_CYC)) i_gap (
    .clk_i, .rst_ni, .clr_i(state_q != ST_GAP), .inc_i(state_q == ST_GAP),
    .hit_o(gap_hit)
  );

  sep_span_cnt #(.LIMIT(MAX_POLLS)) i_poll (
    .clk_i, .rst_ni, .clr_i(state_q == ST_IDLE), .inc_i(poll_sample && !do_i),
    .hit_o(poll_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      early_q <= 1'b0;
      ph_q    <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cs_q    <= 1'b1;
          sck_q   <= 1'b0;
          early_q <= early_mode_i;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          sck_q <= ~sck_q;
          if (sck_q && sr_last) begin
            if (early_q) begin
              cs_q    <= 1'b0;
              state_q <= ST_GAP;
            end else begin
              state_q <= ST_TAIL;
            end
          end
        end
        ST_TAIL: if (tick) begin
          cs_q    <= 1'b0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (gap_hit) begin
          cs_q    <= 1'b1;
          ph_q    <= 1'b0;
          state_q <= ST_POLL;
        end
        ST_POLL: if (tick) begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (do_i) begin
              state_q <= ST_CLEAR;
            end else if (poll_hit) begin
              cs_q    <= 1'b0;
              tmo_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_CLEAR: if (tick) begin
          sck_q <= ~sck_q;
          if (sck_q) begin
            cs_q    <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SHIFT, ST_TAIL: di_o = sr_bit;
      ST_CLEAR:          di_o = 1'b1;
      default:           di_o = 1'b0;
    endcase
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign cs_o      = cs_q;
  assign sck_o     = sck_q;
endmodule

// File: rtl/sep_erase_ctrl_chk.sv
module sep_erase_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic cs_o,
  input logic sck_o,
  input logic di_o
);
  assert_di_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(di_o));

  assert_sck_low_no_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sck_o);

  assert_result_drops_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> $fell(cs_o));

  assert_result_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  assert_idle_cs_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cs_o);

  assert_busy_ends_on_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || timeout_o));

  assert_start_accepted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_result_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> !busy_o);
endmodule

bind sep_erase_ctrl sep_erase_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .timeout_o(timeout_o), .cs_o(cs_o), .sck_o(sck_o),
  .di_o(di_o)
);

// File: tb/test_sep_erase_ctrl.sv
`timescale 1ns/1ps
module test_sep_erase_ctrl;
  localparam int AW   = 7;
  localparam int H    = 3;
  localparam int MAXP = 8;
  localparam int CSL  = (250 + 5 - 1) / 5;
  localparam int FW   = AW + 3;

  typedef struct {
    logic [AW-1:0] addr;
    bit            early;
    bit            tmo;
    int            start_n;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, early_mode_i = 1'b0, do_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic busy_o, done_o, timeout_o, cs_o, sck_o, di_o;

  int n_cmp = 0, n_bad = 0, cyc = 0, dev_busy_len = 0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  sep_erase_ctrl #(.ADDR_W(AW), .DIV_HALF(H), .CLK_NS(5), .CS_LOW_NS(250), .MAX_POLLS(MAXP))
    i_sep_erase_ctrl (
      .clk_i(clk), .rst_ni, .start_i, .addr_i, .early_mode_i, .busy_o, .done_o,
      .timeout_o, .cs_o, .sck_o, .di_o, .do_i);

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // memory model: do_i high during frame and gap (ignored), ready level while polled
  initial begin
    int sess = 0, waitc = 0;
    logic pcs = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (!busy_o) begin sess = 0; waitc = 0; end
      else begin
        if (pcs && !cs_o) sess++;
        if (sess > 0) waitc++;
      end
      pcs = cs_o;
      do_i = (cs_o && sess == 1) ? (waitc >= dev_busy_len) : 1'b1;
    end
  end

  // monitor / scoreboard
  int phase = 0, nbits = 0, first_rise = 0, last_rise = 0, fall_n = 0, gap = 0;
  int rise_n = 0, ready_k = 0, clear_n = 0, clear_rise = 0;
  bit spacing_ok = 1, clear_bit = 0;
  logic [FW-1:0] obs = '0;
  logic p_sck = 1'b0, p_cs = 1'b0;

  always @(negedge clk) begin
    item_t it;
    cyc++;
    if (rst_ni && (done_o || timeout_o)) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected result", 1, 0);
      else begin
        it = exp_q.pop_front();
        chk(nbits == FW && obs == {3'b111, it.addr}, "R1 erase frame bits", obs, {3'b111, it.addr});
        chk(first_rise - it.start_n == H + 1, "R2 first SCK rise", first_rise - it.start_n, H + 1);
        chk(spacing_ok, "R2 SCK rise spacing", spacing_ok, 1);
        chk(fall_n - last_rise == (it.early ? H : 2 * H), "R3 CS tail after last bit",
            fall_n - last_rise, it.early ? H : 2 * H);
        chk(gap == CSL, "R4,R6 CS low gap", gap, CSL);
        chk(!busy_o && !cs_o, "R9 idle at result", {busy_o, cs_o}, 0);
        if (it.tmo) begin
          chk(timeout_o && !done_o, "R8 timeout flag", {timeout_o, done_o}, 2);
          chk(cyc - rise_n == 2 * H * MAXP, "R8 timeout timing", cyc - rise_n, 2 * H * MAXP);
          chk(clear_n == 0, "R8 no clear pulse", clear_n, 0);
        end else begin
          chk(done_o && !timeout_o, "R5 done flag", {done_o, timeout_o}, 2);
          chk(ready_k > 0, "R5 ready sample seen", ready_k, 1);
          chk(clear_rise == rise_n + 2 * H * ready_k + H, "R5 clear follows first ready sample",
              clear_rise - rise_n, 2 * H * ready_k + H);
          chk(clear_n == 1 && clear_bit, "R7 clear start bit", clear_n, 1);
          chk(cyc == rise_n + 2 * H * ready_k + 2 * H, "R7 done at CS fall",
              cyc - rise_n, 2 * H * ready_k + 2 * H);
        end
      end
      phase = 0;
    end else begin
      case (phase)
        0: if (cs_o && !p_cs) begin
          phase = 1; nbits = 0; obs = '0; spacing_ok = 1; first_rise = 0;
        end
        1: if (!cs_o) begin
          fall_n = cyc; gap = 1; phase = 2;
        end else if (sck_o && !p_sck) begin
          if (nbits == 0) first_rise = cyc;
          else if (cyc - last_rise != 2 * H) spacing_ok = 0;
          last_rise = cyc;
          obs = {obs[FW-2:0], di_o};
          nbits++;
        end
        2: if (!cs_o) gap++;
           else begin
             rise_n = cyc; ready_k = 0; clear_n = 0; clear_bit = 0; phase = 3;
           end
        3: begin
          if (ready_k == 0 && ((cyc - rise_n + 1) % (2 * H)) == 0 && do_i)
            ready_k = (cyc - rise_n + 1) / (2 * H);
          if (sck_o && !p_sck) begin
            clear_n++; clear_bit = di_o; clear_rise = cyc;
          end
        end
        default: phase = 0;
      endcase
    end
    p_sck = sck_o;
    p_cs  = cs_o;
  end

  task automatic run_erase(input logic [AW-1:0] a, input bit early, input int blen,
                           input bit exp_tmo, input bit poke);
    item_t it;
    @(negedge clk); #1;
    dev_busy_len = blen;
    it.addr = a; it.early = early; it.tmo = exp_tmo; it.start_n = cyc;
    exp_q.push_back(it);
    addr_i = a; early_mode_i = early; start_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    #1 start_i = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      #1 start_i = 1'b1; addr_i = ~a; early_mode_i = ~early;
      @(negedge clk); #1 start_i = 1'b0;
    end
    do @(negedge clk); while (!(done_o || timeout_o));
    repeat (6) @(negedge clk);
    chk(!busy_o && !cs_o, "R9 no restart after result", {busy_o, cs_o}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk({cs_o, sck_o, di_o, busy_o, done_o, timeout_o} == 6'b0, "R10 reset outputs",
            {cs_o, sck_o, di_o, busy_o, done_o, timeout_o}, 0);
        #1 rst_ni = 1'b1;
        repeat (3) @(negedge clk);
        chk({cs_o, busy_o} == 2'b0, "R10 idle after reset", {cs_o, busy_o}, 0);
        run_erase(7'h55, 1'b0, 0,     1'b0, 1'b0);
        run_erase(7'h2A, 1'b1, 80,    1'b0, 1'b0);
        run_erase(7'h7F, 1'b0, 10000, 1'b1, 1'b0);
        run_erase(7'h00, 1'b1, 0,     1'b0, 1'b1);
        run_erase(7'h01, 1'b1, 10000, 1'b1, 1'b1);
        run_erase(7'h40, 1'b0, 95,    1'b0, 1'b0);
        chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule